// File: doc/BRIEF.md
# RAM Write Holding Buffer

This block sits between a requester and a single-port synchronous RAM and gives reads priority over writes on the RAM port. Every read is sent to the RAM in the cycle it is requested and its data comes back exactly one cycle later. Writes never occupy the port in the cycle they arrive: each accepted write is parked in a one-entry holding register (address, data and byte mask) and is written to the RAM later, in a cycle where the port is not needed for a read.

A parked write is committed in the first cycle with no request at all, or in the cycle a further write arrives (the older write goes to the RAM and the newer one takes its place). A stream of reads may keep the write parked for any number of cycles, whatever addresses those reads use. A read of the parked address has the parked bytes merged into the RAM data byte by byte, so the requester always sees memory as if every operation had taken effect in issue order.

Top module: `wr_hold_buf`

## Requirements
- R1: After reset no write is held, `rvalid` is 0, and while no request arrives and nothing is held `ramReq` stays 0.
- R2: A read (`req`=1, `we`=0) accepted in cycle t raises `rvalid` in cycle t+1 only, carrying that read's data; `rvalid` is 0 in every cycle that does not follow a read.
- R3: In a read cycle the RAM port performs that read at once: `ramReq`=1, `ramWe`=0, `ramAddr`=`addr`.
- R4: A write is never sent to the RAM in its own cycle; it is held, and it stays held through any run of reads, whether or not they target its address (no RAM write happens in a read cycle).
- R5: In the first cycle with `req`=0 while a write is held, the RAM port writes the held address, data and byte mask (`ramReq`=1, `ramWe`=1), and the holding register becomes empty.
- R6: A write arriving while a write is held commits the held write to the RAM in that same cycle and then holds the new one; a write arriving with nothing held causes no RAM access.
- R7: A read of the held address returns, for each byte whose held mask bit is 1, the held byte, and for every other byte the RAM byte.
- R8: Byte mask bit i covers data bits [8i+7:8i]; a committed write presents the write's own mask on `ramWmask`, so only enabled bytes change in the RAM.
- R9: Read data and final RAM contents match a model that applies every write, masked, immediately in issue order.
- R10: A read of any address other than the held one returns the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request valid; always accepted |
| we | input | 1 | 1 for write, 0 for read |
| addr | input | AddrWidth | Word address |
| wdata | input | DataWidth | Write data |
| wmask | input | DataWidth/8 | Byte enables of a write |
| rvalid | output | 1 | Read data valid, one cycle after a read |
| rdata | output | DataWidth | Read data, forwarded bytes merged in |
| ramReq | output | 1 | RAM port access strobe |
| ramWe | output | 1 | RAM port write enable |
| ramAddr | output | AddrWidth | RAM port address |
| ramWdata | output | DataWidth | RAM port write data |
| ramWmask | output | DataWidth/8 | RAM port byte enables |
| ramRdata | input | DataWidth | RAM read data, valid one cycle after a RAM read |

## Verification
The RAM-port results (R1, R3 to R6, R8) are combinational in the current cycle, so the bench checks them shortly after driving inputs on the falling edge and before the next rising edge. Read results (R2, R7, R9, R10) are due one rising edge after the read, so the bench records the expected word when the read is driven and compares `rvalid` and `rdata` at the following falling edge, every cycle. Expected read data comes from a model memory that applies each write immediately in issue order, and after the traffic drains the bench RAM is compared with that model word by word.

// File: rtl/whb_pkg.sv
package whb_pkg;

  // Strobes from the control to the datapath, one set per cycle.
  typedef struct packed {
    logic ramReq;    // RAM port is used this cycle
    logic ramWe;     // the RAM access is the held-write commit
    logic holdLoad;  // capture the incoming write into the holding register
    logic fwdLoad;   // a read is issued: capture the forwarding bytes
    logic heldValid; // holding register holds a write this cycle
  } whbStrobes_t;

endpackage

// File: rtl/whb_ctrl.sv
module whb_ctrl
  import whb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        req,
  input  logic        we,
  output whbStrobes_t strb,
  output logic        rvalid
);

  logic heldValidQ;
  logic heldValidD;
  logic isRead;
  logic isWrite;

  always_comb begin
    isRead  = req & ~we;
    isWrite = req & we;

    // A write always parks; an idle cycle drains; a read leaves it alone.
    if (isWrite) begin
      heldValidD = 1'b1;
    end else if (!req) begin
      heldValidD = 1'b0;
    end else begin
      heldValidD = heldValidQ;
    end

    strb.ramReq    = isRead | heldValidQ;
    strb.ramWe     = heldValidQ & ~isRead;
    strb.holdLoad  = isWrite;
    strb.fwdLoad   = isRead;
    strb.heldValid = heldValidQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldValidQ <= 1'b0;
      rvalid     <= 1'b0;
    end else begin
      heldValidQ <= heldValidD;
      rvalid     <= isRead;
    end
  end

endmodule

// File: rtl/whb_datapath.sv
module whb_datapath
  import whb_pkg::*;
#(
  parameter int AddrWidth = 10,
  parameter int DataWidth = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  whbStrobes_t            strb,
  input  logic [AddrWidth-1:0]   addr,
  input  logic [DataWidth-1:0]   wdata,
  input  logic [DataWidth/8-1:0] wmask,
  output logic [AddrWidth-1:0]   ramAddr,
  output logic [DataWidth-1:0]   ramWdata,
  output logic [DataWidth/8-1:0] ramWmask,
  input  logic [DataWidth-1:0]   ramRdata,
  output logic [DataWidth-1:0]   rdata
);

  localparam int NumBytes = DataWidth / 8;

  logic [AddrWidth-1:0] heldAddr;
  logic [DataWidth-1:0] heldData;
  logic [NumBytes-1:0]  heldMask;
  logic [DataWidth-1:0] fwdData;
  logic [NumBytes-1:0]  fwdMask;
  logic                 addrHit;

  assign addrHit  = strb.heldValid && (addr == heldAddr);
  assign ramAddr  = (strb.ramReq && strb.ramWe) ? heldAddr : addr;
  assign ramWdata = heldData;
  assign ramWmask = heldMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldData <= '0;
      heldMask <= '0;
    end else if (strb.holdLoad) begin
      heldAddr <= addr;
      heldData <= wdata;
      heldMask <= wmask;
    end
  end

  // Snapshot of the held bytes for the read in flight; the holding
  // register may be replaced by a write in the very next cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdData <= '0;
      fwdMask <= '0;
    end else if (strb.fwdLoad) begin
      fwdData <= heldData;
      fwdMask <= addrHit ? heldMask : '0;
    end
  end

  for (genvar b = 0; b < NumBytes; b++) begin : g_merge
    assign rdata[8*b +: 8] = fwdMask[b] ? fwdData[8*b +: 8] : ramRdata[8*b +: 8];
  end

endmodule

// File: rtl/wr_hold_buf.sv
module wr_hold_buf
  import whb_pkg::*;
#(
  parameter int AddrWidth = 10,
  parameter int DataWidth = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   req,
  input  logic                   we,
  input  logic [AddrWidth-1:0]   addr,
  input  logic [DataWidth-1:0]   wdata,
  input  logic [DataWidth/8-1:0] wmask,
  output logic                   rvalid,
  output logic [DataWidth-1:0]   rdata,
  output logic                   ramReq,
  output logic                   ramWe,
  output logic [AddrWidth-1:0]   ramAddr,
  output logic [DataWidth-1:0]   ramWdata,
  output logic [DataWidth/8-1:0] ramWmask,
  input  logic [DataWidth-1:0]   ramRdata
);

  whbStrobes_t strb;

  whb_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .req    (req),
    .we     (we),
    .strb   (strb),
    .rvalid (rvalid)
  );

  whb_datapath #(
    .AddrWidth (AddrWidth),
    .DataWidth (DataWidth)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .wdata    (wdata),
    .wmask    (wmask),
    .ramAddr  (ramAddr),
    .ramWdata (ramWdata),
    .ramWmask (ramWmask),
    .ramRdata (ramRdata),
    .rdata    (rdata)
  );

  assign ramReq = strb.ramReq;
  assign ramWe  = strb.ramWe;

endmodule

// File: rtl/whb_checker.sv
module whb_checker #(
  parameter int AddrWidth = 10,
  parameter int DataWidth = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   req,
  input logic                   we,
  input logic [AddrWidth-1:0]   addr,
  input logic [DataWidth-1:0]   wdata,
  input logic [DataWidth/8-1:0] wmask,
  input logic                   rvalid,
  input logic                   ramReq,
  input logic                   ramWe,
  input logic [AddrWidth-1:0]   ramAddr,
  input logic [DataWidth-1:0]   ramWdata,
  input logic [DataWidth/8-1:0] ramWmask
);

  // Port-level shadow of the outstanding write.
  logic                   pend;
  logic [AddrWidth-1:0]   shAddr;
  logic [DataWidth-1:0]   shData;
  logic [DataWidth/8-1:0] shMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend   <= 1'b0;
      shAddr <= '0;
      shData <= '0;
      shMask <= '0;
    end else if (req && we) begin
      pend   <= 1'b1;
      shAddr <= addr;
      shData <= wdata;
      shMask <= wmask;
    end else if (!req) begin
      pend <= 1'b0;
    end
  end

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!req && !pend) |-> !ramReq);

  p_rvalid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (req && !we) |=> rvalid);

  p_no_rvalid_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(req && !we) |=> !rvalid);

  p_read_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (req && !we) |-> (ramReq && !ramWe && ramAddr == addr));

  p_park_r4: assert property (@(posedge clk) disable iff (!rstN)
    (req && we && !pend) |-> !ramReq);

  p_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!req && pend) |-> (ramReq && ramWe && ramAddr == shAddr && ramWdata == shData));

  p_replace_r6: assert property (@(posedge clk) disable iff (!rstN)
    (req && we && pend) |-> (ramReq && ramWe && ramAddr == shAddr && ramWdata == shData));

  p_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ramReq && ramWe) |-> (ramWmask == shMask));

endmodule

bind wr_hold_buf whb_checker #(
  .AddrWidth (AddrWidth),
  .DataWidth (DataWidth)
) i_whb_checker (
  .clk      (clk),
  .rstN     (rstN),
  .req      (req),
  .we       (we),
  .addr     (addr),
  .wdata    (wdata),
  .wmask    (wmask),
  .rvalid   (rvalid),
  .ramReq   (ramReq),
  .ramWe    (ramWe),
  .ramAddr  (ramAddr),
  .ramWdata (ramWdata),
  .ramWmask (ramWmask)
);

// File: tb/test_wr_hold_buf.sv
`timescale 1ns/1ps
module test_wr_hold_buf;

  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int NB    = DW / 8;
  localparam int Depth = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] wmask = '0;
  logic          rvalid;
  logic [DW-1:0] rdata;
  logic          ramReq;
  logic          ramWe;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramWdata;
  logic [NB-1:0] ramWmask;
  logic [DW-1:0] ramRdata = '0;

  always #10 clk = ~clk;

  wr_hold_buf #(.AddrWidth(AW), .DataWidth(DW)) i_wr_hold_buf (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .wmask(wmask), .rvalid(rvalid), .rdata(rdata),
    .ramReq(ramReq), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramWmask(ramWmask), .ramRdata(ramRdata)
  );

  // Bench RAM: single port, registered read.
  logic [DW-1:0] ramMem [Depth];
  always @(posedge clk) begin
    if (ramReq) begin
      if (ramWe) begin
        for (int b = 0; b < NB; b++)
          if (ramWmask[b]) ramMem[ramAddr][8*b +: 8] <= ramWdata[8*b +: 8];
      end else begin
        ramRdata <= ramMem[ramAddr];
      end
    end
  end

  // Reference: writes applied at once, in issue order.
  logic [DW-1:0] refMem [Depth];
  bit            pend = 1'b0;
  logic [AW-1:0] pA;
  logic [DW-1:0] pD;
  logic [NB-1:0] pM;

  int nChecks = 0;
  int nFail   = 0;
  int cycCnt  = 0;

  function automatic logic [DW-1:0] mergeW(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                           input logic [NB-1:0] m);
    logic [DW-1:0] r = old;
    for (int b = 0; b < NB; b++)
      if (m[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, check the RAM port before
  // the rising edge, check the read result at the next falling edge.
  task automatic cyc(input bit r, input bit w, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [NB-1:0] m, input string tag);
    bit            expV;
    logic [DW-1:0] expD;
    req = r; we = w; addr = a; wdata = d; wmask = m;
    #2;
    if (r && !w) begin
      chk(ramReq && !ramWe && ramAddr == a, "R3 read owns RAM port", {ramReq, ramWe, ramAddr}, {2'b10, a});
    end else if (pend) begin
      chk(ramReq && ramWe && ramAddr == pA && ramWdata == pD,
          w ? "R6 held write committed by new write" : "R5 held write committed when idle",
          {ramReq, ramWe, ramAddr, ramWdata}, {2'b11, pA, pD});
      chk(ramWmask == pM, "R8 commit byte mask", ramWmask, pM);
    end else begin
      chk(!ramReq, w ? "R4 write not sent to RAM in its cycle" : "R1 idle RAM port quiet",
          ramReq, 0);
    end
    expV = r && !w;
    expD = refMem[a];
    if (r && w) begin
      refMem[a] = mergeW(refMem[a], d, m);
      pend = 1'b1; pA = a; pD = d; pM = m;
    end else if (!r) begin
      pend = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(rvalid == expV, "R2 rvalid one cycle after read", rvalid, expV);
    if (expV) chk(rdata == expD, tag, rdata, expD);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt > 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycCnt);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < Depth; i++) begin
      ramMem[i] = (i * 32'h01030507) ^ 32'h5A5A0000;
      refMem[i] = (i * 32'h01030507) ^ 32'h5A5A0000;
    end
    repeat (3) @(negedge clk);
    chk(rvalid == 1'b0, "R1 rvalid low in reset", rvalid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rvalid == 1'b0 && ramReq == 1'b0, "R1 quiet after reset", {rvalid, ramReq}, 0);

    cyc(0, 0, 0, 0, 0, "R1");
    cyc(1, 0, 5, 0, 0, "R10 plain read");
    // Full write, forwarded, then an unrelated read keeps it held.
    cyc(1, 1, 7, 32'hDEADBEEF, 4'hF, "R4");
    cyc(1, 0, 7, 0, 0, "R7 full forward");
    cyc(1, 0, 9, 0, 0, "R10 other address while held");
    cyc(1, 0, 7, 0, 0, "R4 still held after read of other address");
    cyc(0, 0, 0, 0, 0, "R5");
    cyc(1, 0, 7, 0, 0, "R9 committed data read from RAM");
    // Partial mask: byte merge.
    cyc(1, 1, 12, 32'h11223344, 4'b0101, "R4");
    cyc(1, 0, 12, 0, 0, "R7 per-byte merge");
    cyc(0, 0, 0, 0, 0, "R5");
    cyc(1, 0, 12, 0, 0, "R8 only masked bytes changed");
    // Back-to-back writes.
    cyc(1, 1, 20, 32'hA0A0A0A0, 4'hF, "R4");
    cyc(1, 1, 21, 32'hB1B1B1B1, 4'b1100, "R6");
    cyc(1, 0, 20, 0, 0, "R6 older write reached RAM");
    cyc(1, 0, 21, 0, 0, "R7 newer write forwarded");
    // Same address twice with different masks.
    cyc(1, 1, 30, 32'hCAFEF00D, 4'b0011, "R6");
    cyc(1, 1, 30, 32'h12345678, 4'b0110, "R6");
    cyc(1, 0, 30, 0, 0, "R9 same-address overwrite order");
    cyc(0, 0, 0, 0, 0, "R5");
    cyc(1, 0, 30, 0, 0, "R9 same-address after commit");
    // Long read run keeps write parked.
    cyc(1, 1, 40, 32'h0F0F0F0F, 4'b1000, "R4");
    for (int k = 0; k < 20; k++) cyc(1, 0, AW'(38 + (k % 4)), 0, 0, "R4 read run with held write");
    cyc(0, 0, 0, 0, 0, "R5");
    // Mixed traffic on a small address window.
    for (int k = 0; k < 3000; k++) begin
      int op = $urandom % 4;
      logic [AW-1:0] a = AW'($urandom % 16);
      if (op == 0) cyc(0, 0, a, 0, 0, "R9 random");
      else if (op == 1) cyc(1, 1, a, DW'($urandom), NB'($urandom), "R9 random");
      else cyc(1, 0, a, 0, 0, "R9 random read");
    end
    cyc(0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 64; i++)
      chk(ramMem[i] == refMem[i], "R9 final RAM contents", ramMem[i], refMem[i]);
    summary();
    $finish;
  end

endmodule